// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Master

This block is the serial master used to configure a display panel over a four-wire serial link whose words are nine bits long. The top bit of every word on the wire says whether the other eight bits are a command opcode (bit clear) or a data byte (bit set). A host starts one transaction with a one-cycle request. The request carries a command byte, up to `MAX_PARAM` parameter bytes packed into one vector, and a read length of up to `MAX_READ` bytes. The block then drives chip select, the serial clock and the outgoing data line until the whole exchange is finished.

The link runs in SPI mode 0. The serial clock rests low. Each bit spends `HALF_DIV` system clocks low and then `HALF_DIV` clocks high. Outgoing data changes on the falling edge, and incoming data is sampled on the rising edge. A read of several bytes begins with one extra dummy clock, so its first word is nine clocks long. A read of a single byte has no dummy clock. Received bytes are stored by position and can be read at any time through an index port. A one-cycle completion pulse marks the cycle in which chip select is released.

Top module: `panel_cmd9_master`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `spi_cs_n` is 1 and `spi_sclk`, `spi_mosi`, `busy` and `done` are 0. All stored read bytes reset to 0.
- R2: A `start` seen while idle pulls `spi_cs_n` low in the next cycle. It stays low until the clock edge that produces the final falling edge of `spi_sclk`. In that same cycle `spi_cs_n` returns high, `busy` drops and `done` is 1 for exactly one cycle. A new `start` is accepted in that cycle.
- R3: Each serial bit is `HALF_DIV` cycles with `spi_sclk` low followed by `HALF_DIV` cycles with it high. `spi_mosi` changes only when `spi_sclk` falls, or when a transaction begins. `spi_miso` is sampled on the clock edge that raises `spi_sclk`.
- R4: The first word is 9 bits long, sent most significant bit first: a 0, then `cmd_byte[7]` down to `cmd_byte[0]`.
- R5: After the command word, parameter byte k (`param_data[8k+7:8k]`) is sent for k = 0 up to `param_cnt`-1, in that order. Each byte goes out as a 9-bit word whose first bit is 1, followed by its bits 7 down to 0.
- R6: With a read length of 1, exactly 8 clocks follow the last written word with `spi_mosi` held at 0. Byte 0 is the 8 sampled bits, and the first sampled bit is its bit 7.
- R7: With a read length n > 1, the first read word takes 9 clocks. Its first sampled bit is discarded and the last 8 bits form byte 0. Bytes 1 to n-1 then take 8 clocks each, most significant bit first, with `spi_mosi` at 0.
- R8: `rd_data` shows stored byte `rd_sel` for any `rd_sel` below `MAX_READ`. A transaction with a read length of 0 leaves the stored bytes unchanged. A `rd_sel` of `MAX_READ` or more gives 0.
- R9: A `param_cnt` above `MAX_PARAM` is treated as `MAX_PARAM`. A `read_cnt` above `MAX_READ` is treated as `MAX_READ`.
- R10: A `start` raised while `busy` is 1 has no effect on the serial waveform, the stored bytes or the completion pulse.
- R11: `cmd_byte`, `param_data`, `param_cnt` and `read_cnt` are captured in the cycle `start` is accepted. Changing them afterwards does not alter the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a transaction |
| cmd_byte | input | 8 | Command opcode |
| param_data | input | 8*MAX_PARAM | Parameter bytes, byte k in bits 8k+7:8k |
| param_cnt | input | $clog2(MAX_PARAM+1) | Number of parameter bytes |
| read_cnt | input | $clog2(MAX_READ+1) | Number of bytes to read |
| rd_sel | input | $clog2(MAX_READ)+1 | Index of the stored read byte to show |
| rd_data | output | 8 | Stored read byte selected by rd_sel |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_miso | input | 1 | Serial data from the panel |

## Verification
The completion of one transaction and the acceptance of the next can fall in the same cycle. The release of chip select together with the `done` pulse is the only cycle in which a pending `start` can be taken. The bench provokes this by holding `start` high across the end of a transaction. Its per-cycle reference model, built from queues of expected bit phases, must then show chip select falling again on the very next edge, with no idle gap and no restart earlier in the transaction. A second overlap is a `start` pulse in the middle of a transaction together with changed inputs. It is judged the same way: the waveform is compared on every clock, and the stored read bytes are checked afterwards.

// File: rtl/p9_pkg.sv
package p9_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] p9_word_t;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_PARAM = 2'd2,
    ST_READ  = 2'd3
  } p9_state_e;
endpackage

// File: rtl/p9_bit_timer.sv
// Serial clock generator: HALF_DIV cycles low, HALF_DIV cycles high per bit.
module p9_bit_timer #(
  parameter int HALF_DIV = 2,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          half_end;

  assign half_end  = (cnt_q == CW'(HALF_DIV - 1));
  assign rise_tick = run && !sclk_q && half_end;
  assign fall_tick = run && sclk_q && half_end;
  assign sclk      = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (half_end) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end
endmodule

// File: rtl/p9_shift_unit.sv
// Transmit and receive shift registers, MSB first.
module p9_shift_unit
  import p9_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld_en,
  input  p9_word_t ld_word,
  input  logic     sh_en,
  input  logic     smp_en,
  input  logic     miso,
  output logic     mosi,
  output logic [7:0] rx_byte
);
  p9_word_t   tx_q, tx_d;
  logic [7:0] rx_q, rx_d;

  assign mosi    = tx_q[WORD_W-1];
  assign rx_byte = rx_q;

  always_comb begin
    tx_d = tx_q;
    if (ld_en)      tx_d = ld_word;
    else if (sh_en) tx_d = {tx_q[WORD_W-2:0], 1'b0};
  end

  always_comb begin
    rx_d = rx_q;
    if (smp_en) rx_d = {rx_q[6:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end
endmodule

// File: rtl/p9_rx_store.sv
// Indexed storage for received bytes.
module p9_rx_store #(
  parameter int DEPTH = 4,
  parameter int IW    = 3,
  parameter int SW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic [SW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  logic [7:0] slot_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [7:0] q;
    logic       hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_byte;
    end
    assign slot_w[g] = q;
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == SW'(i)) rd_byte = slot_w[i];
  end
endmodule

// File: rtl/panel_cmd9_master.sv
module panel_cmd9_master
  import p9_pkg::*;
#(
  parameter int MAX_PARAM = 4,
  parameter int MAX_READ  = 4,
  parameter int HALF_DIV  = 2,
  localparam int PCW = $clog2(MAX_PARAM + 1),
  localparam int RCW = $clog2(MAX_READ + 1),
  localparam int RSW = $clog2(MAX_READ) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [7:0]             cmd_byte,
  input  logic [8*MAX_PARAM-1:0] param_data,
  input  logic [PCW-1:0]         param_cnt,
  input  logic [RCW-1:0]         read_cnt,
  input  logic [RSW-1:0]         rd_sel,
  output logic [7:0]             rd_data,
  output logic                   busy,
  output logic                   done,
  output logic                   spi_sclk,
  output logic                   spi_cs_n,
  output logic                   spi_mosi,
  input  logic                   spi_miso
);
  p9_state_e              state_q, state_d;
  logic [PCW-1:0]         pidx_q, pidx_d, pcnt_q, pcnt_d, nxt_p;
  logic [RCW-1:0]         ridx_q, ridx_d, rcnt_q, rcnt_d;
  logic [3:0]             bcnt_q, bcnt_d;
  logic                   wlen9_q, wlen9_d;
  logic [8*MAX_PARAM-1:0] pdata_q, pdata_d;
  logic                   cs_n_q, cs_n_d;
  logic                   done_q, done_d;
  logic                   run, rise_tick, fall_tick, last_bit;
  logic                   ld_en, sh_en, st_en;
  p9_word_t               ld_word;
  logic [7:0]             sel_byte, rx_byte;

  assign run      = (state_q != ST_IDLE);
  assign busy     = run;
  assign done     = done_q;
  assign spi_cs_n = cs_n_q;
  assign last_bit = wlen9_q ? (bcnt_q == 4'd8) : (bcnt_q == 4'd7);
  assign nxt_p    = (state_q == ST_CMD) ? '0 : pidx_q + PCW'(1);

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < MAX_PARAM; i++)
      if (nxt_p == PCW'(i)) sel_byte = pdata_q[i*8 +: 8];
  end

  always_comb begin
    state_d = state_q;
    pidx_d  = pidx_q;
    ridx_d  = ridx_q;
    pcnt_d  = pcnt_q;
    rcnt_d  = rcnt_q;
    bcnt_d  = bcnt_q;
    wlen9_d = wlen9_q;
    pdata_d = pdata_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    ld_en   = 1'b0;
    ld_word = '0;
    sh_en   = 1'b0;
    st_en   = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start) begin
        state_d = ST_CMD;
        pcnt_d  = (param_cnt > PCW'(MAX_PARAM)) ? PCW'(MAX_PARAM) : param_cnt;
        rcnt_d  = (read_cnt > RCW'(MAX_READ)) ? RCW'(MAX_READ) : read_cnt;
        pdata_d = param_data;
        cs_n_d  = 1'b0;
        ld_en   = 1'b1;
        ld_word = {1'b0, cmd_byte};
        bcnt_d  = '0;
        wlen9_d = 1'b1;
        pidx_d  = '0;
        ridx_d  = '0;
      end
    end else if (fall_tick) begin
      if (!last_bit) begin
        sh_en  = 1'b1;
        bcnt_d = bcnt_q + 4'd1;
      end else begin
        bcnt_d = '0;
        ld_en  = 1'b1;
        if (state_q != ST_READ) begin
          if (nxt_p < pcnt_q) begin
            state_d = ST_PARAM;
            pidx_d  = nxt_p;
            ld_word = {1'b1, sel_byte};
            wlen9_d = 1'b1;
          end else if (rcnt_q != '0) begin
            state_d = ST_READ;
            ridx_d  = '0;
            wlen9_d = (rcnt_q > RCW'(1));
          end else begin
            state_d = ST_IDLE;
            cs_n_d  = 1'b1;
            done_d  = 1'b1;
          end
        end else begin
          st_en = 1'b1;
          if (ridx_q + RCW'(1) < rcnt_q) begin
            ridx_d  = ridx_q + RCW'(1);
            wlen9_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
            cs_n_d  = 1'b1;
            done_d  = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pidx_q  <= '0;
      ridx_q  <= '0;
      pcnt_q  <= '0;
      rcnt_q  <= '0;
      bcnt_q  <= '0;
      wlen9_q <= 1'b0;
      pdata_q <= '0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pidx_q  <= pidx_d;
      ridx_q  <= ridx_d;
      pcnt_q  <= pcnt_d;
      rcnt_q  <= rcnt_d;
      bcnt_q  <= bcnt_d;
      wlen9_q <= wlen9_d;
      pdata_q <= pdata_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
    end
  end

  p9_bit_timer #(.HALF_DIV(HALF_DIV)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sclk     (spi_sclk),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  p9_shift_unit i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en),
    .ld_word(ld_word),
    .sh_en  (sh_en),
    .smp_en (rise_tick),
    .miso   (spi_miso),
    .mosi   (spi_mosi),
    .rx_byte(rx_byte)
  );

  p9_rx_store #(.DEPTH(MAX_READ), .IW(RCW), .SW(RSW)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (st_en),
    .wr_idx (ridx_q),
    .wr_byte(rx_byte),
    .rd_idx (rd_sel),
    .rd_byte(rd_data)
  );
endmodule

// File: rtl/p9_checker.sv
module p9_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi
);
  // R2: completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: chip select rises only together with completion
  a_r2_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);
  // R2: select held low throughout a transaction
  a_r2_cs_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);
  // R1: idle lines rest low
  a_r1_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sclk && !spi_mosi));
  // R3: data steady while serial clock high
  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  // R10: a request during a transaction never restarts the select
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !$fell(spi_cs_n));
endmodule

bind panel_cmd9_master p9_checker i_p9_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi)
);

// File: tb/test_panel_cmd9_master.sv
module test_panel_cmd9_master;
  localparam int MAXP = 4;
  localparam int MAXR = 4;
  localparam int HD   = 2;
  localparam logic [4:0] IDLE_V = 5'b01000; // {busy,cs_n,sclk,mosi,done}
  localparam logic [4:0] DONE_V = 5'b01001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start, spi_miso;
  logic [7:0]  cmd_byte;
  logic [31:0] param_data;
  logic [2:0]  param_cnt, read_cnt, rd_sel;
  logic [7:0]  rd_data;
  logic        busy, done, spi_sclk, spi_cs_n, spi_mosi;

  int n_cmp = 0;
  int n_bad = 0;
  int wd    = 0;
  int rise_n = 0;
  logic sclk_prev = 1'b0;
  bit   stream [0:255];

  always #5 clk = ~clk;

  panel_cmd9_master #(.MAX_PARAM(MAXP), .MAX_READ(MAXR), .HALF_DIV(HD)) i_panel_cmd9_master (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_byte(cmd_byte),
    .param_data(param_data), .param_cnt(param_cnt), .read_cnt(read_cnt),
    .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .done(done),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---------------- reference model ----------------
  logic [4:0] mq [$];
  int         tq [$];
  logic [4:0] exp_v = IDLE_V;
  int         exp_tag = 1;

  task automatic mpush(logic [4:0] v, int t);
    mq.push_back(v);
    tq.push_back(t);
  endtask

  task automatic mbit(logic b, int t);
    repeat (HD) mpush({3'b100, b, 1'b0}, t);
    repeat (HD) mpush({3'b101, b, 1'b0}, t);
  endtask

  task automatic build(logic [7:0] c, logic [31:0] pd, int pc, int rc);
    int rbits;
    if (pc > MAXP) pc = MAXP;
    if (rc > MAXR) rc = MAXR;
    for (int i = 8; i >= 0; i--) mbit((i == 8) ? 1'b0 : c[i], 4);
    for (int p = 0; p < pc; p++) begin
      mbit(1'b1, 5);
      for (int i = 7; i >= 0; i--) mbit(pd[p*8+i], 5);
    end
    rbits = (rc == 0) ? 0 : (rc == 1) ? 8 : 8*rc + 1;
    for (int k = 0; k < rbits; k++) mbit(1'b0, (rc == 1) ? 6 : 7);
    mpush(DONE_V, 2);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      tq.delete();
      exp_v   = IDLE_V;
      exp_tag = 1;
    end else begin
      if (mq.size() == 0 && start)
        build(cmd_byte, param_data, int'(param_cnt), int'(read_cnt));
      if (mq.size() > 0) begin
        exp_v   = mq.pop_front();
        exp_tag = tq.pop_front();
      end else begin
        exp_v   = IDLE_V;
        exp_tag = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && wd < 100000) begin
      n_cmp++;
      if ({busy, spi_cs_n, spi_sclk, spi_mosi, done} !== exp_v) begin
        n_bad++;
        $display("FAIL R3 R%0d cycle: actual %b expected %b (busy,cs_n,sclk,mosi,done)",
                 exp_tag, {busy, spi_cs_n, spi_sclk, spi_mosi, done}, exp_v);
      end
    end
  end

  // panel-side data source: next bit after each observed serial rise
  always @(negedge clk) begin
    if (spi_sclk && !sclk_prev) begin
      rise_n++;
      spi_miso <= stream[rise_n];
    end
    sclk_prev = spi_sclk;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual busy %b expected completion", busy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exv, string what);
    n_cmp++;
    if (act !== exv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exv);
    end
  endtask

  function automatic logic [7:0] exp_byte(int base);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[7-b] = stream[base+b];
    return r;
  endfunction

  task automatic txn(logic [7:0] c, logic [31:0] pd, int pc, int rc, bit disturb, string rq);
    int ec, ep, w, base;
    for (int k = 0; k < 256; k++) stream[k] = 1'($urandom_range(0, 1));
    rise_n     = 0;
    spi_miso   = stream[0];
    cmd_byte   = c;
    param_data = pd;
    param_cnt  = 3'(pc);
    read_cnt   = 3'(rc);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R10 / R11: change captured inputs and pulse start mid-transaction
      cmd_byte   = ~c;
      param_data = ~pd;
      param_cnt  = 3'd0;
      read_cnt   = 3'd0;
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk("R2", {31'd0, spi_cs_n}, 32'd1, "select released with done");
    ec = (rc > MAXR) ? MAXR : rc;
    ep = (pc > MAXP) ? MAXP : pc;
    w  = 9 * (1 + ep);
    for (int i = 0; i < ec; i++) begin
      base = (ec == 1) ? w : (i == 0) ? w + 1 : w + 9 + 8*(i-1);
      rd_sel = 3'(i);
      #1;
      chk(rq, {24'd0, rd_data}, {24'd0, exp_byte(base)}, $sformatf("read byte %0d", i));
    end
    @(negedge clk);
  endtask

  logic [7:0] keep0;

  initial begin
    start = 1'b0; cmd_byte = '0; param_data = '0; param_cnt = '0;
    read_cnt = '0; rd_sel = '0; spi_miso = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {27'd0, busy, spi_cs_n, spi_sclk, spi_mosi, done}, {27'd0, IDLE_V}, "outputs in reset");
    chk("R1", {24'd0, rd_data}, 32'd0, "stored byte in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {27'd0, busy, spi_cs_n, spi_sclk, spi_mosi, done}, {27'd0, IDLE_V}, "outputs after reset");

    txn(8'h29, 32'h0, 0, 0, 1'b0, "R4");                   // R4 command only
    txn(8'h3A, 32'h0000_0070, 1, 0, 1'b0, "R5");           // R5 single parameter
    txn(8'hC2, 32'h0001_0002, 3, 0, 1'b0, "R5");           // R5 several parameters
    txn(8'h04, 32'h0, 0, 1, 1'b0, "R6");                   // R6 single-byte read
    txn(8'h09, 32'h0, 0, 3, 1'b0, "R7");                   // R7 multi-byte read
    txn(8'h0F, 32'hA5C3_5A3C, 2, 4, 1'b0, "R7");           // R7 params then read
    txn(8'h55, 32'hDEAD_BEEF, 7, 6, 1'b0, "R9");           // R9 clamped counts
    txn(8'h81, 32'h1234_5678, 1, 2, 1'b1, "R11");          // R10 R11 disturbance

    // R8: out-of-range index and hold over a write-only transaction
    rd_sel = 3'd0;
    #1;
    keep0 = rd_data;
    rd_sel = 3'd4;
    #1;
    chk("R8", {24'd0, rd_data}, 32'd0, "index beyond depth");
    txn(8'h28, 32'h0, 0, 0, 1'b0, "R8");
    rd_sel = 3'd0;
    #1;
    chk("R8", {24'd0, rd_data}, {24'd0, keep0}, "byte kept across write-only");

    // R2: start held high across completion, next transaction begins at once
    cmd_byte = 8'h10; param_data = 32'h0000_00F0; param_cnt = 3'd1; read_cnt = 3'd0;
    start = 1'b1;
    while (done !== 1'b1) @(negedge clk);
    cmd_byte = 8'h11; param_cnt = 3'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R2", {31'd0, busy}, 32'd1, "back-to-back acceptance");
    while (done !== 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule